// File: doc/BRIEF.md
# One-Shot Pulse Generator with Issued Flag

This block turns a level input into a single clock-wide pulse each time the level is raised. A second output stays high after the pulse and stays high for as long as the level remains asserted. It is meant for control paths where a held request must start exactly one action. The held flag lets downstream logic see that the action for the current request has already been started. The input is assumed to be already synchronous to the clock.

The core is a four-state Moore machine held in two D flip-flops, a (bit 1) and b (bit 0). The states, in the order the machine visits them, are idle {a,b}=00, fire 10, mark 11 and wait 01. Only one bit changes on each step. The next-state equations are a_d = (~b & lvl) | (a & ~b) and b_d = a | (b & lvl). The fire state always passes through mark to wait. A level that drops early therefore still completes the sequence, and no further pulse is issued.

Top module: `single_pulse_mem`

## Requirements
- R1: While rst_ni is low the machine is in idle, and pulse_o and held_o are both 0.
- R2: In idle, a high lvl_i at a rising clock edge moves the machine to fire. pulse_o is 1 for exactly that one clock period.
- R3: The fire state always moves to mark, and mark always moves to wait, whatever lvl_i is doing.
- R4: In wait, the machine stays in wait while lvl_i is high and returns to idle at the first edge where lvl_i is low.
- R5: held_o is 1 in mark and wait and 0 in idle and fire. It therefore rises one cycle after pulse_o and falls only after lvl_i has been seen low in wait.
- R6: After a pulse, no further pulse occurs until lvl_i has been sampled low in wait. This also covers a level that drops in fire and is raised again in mark.
- R7: pulse_o and held_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_i | input | 1 | Synchronous level request |
| pulse_o | output | 1 | One-cycle pulse, high in fire |
| held_o | output | 1 | Issued flag, high in mark and wait |

## Verification
The hardest case to reach from the ports is a level that drops during fire and is raised again while the machine is in mark. Here a plain edge detector would issue a second pulse, but this block must not. The stimulus table produces this by driving a one-cycle request and re-raising it on the very next edge. It also covers a request that drops while in mark and returns while in wait. The reset case is reached by pulling rst_ni low right after a pulse, while the sequence is still in flight.

// File: rtl/single_pulse_mem_pkg.sv
package single_pulse_mem_pkg;
  localparam int unsigned ST_W = 2;
  localparam int unsigned A_BIT = 1;
  localparam int unsigned B_BIT = 0;

  typedef enum logic [ST_W-1:0] {
    SP_IDLE = 2'b00,
    SP_WAIT = 2'b01,
    SP_FIRE = 2'b10,
    SP_MARK = 2'b11
  } sp_state_e;
endpackage

// File: rtl/sp_next_state.sv
module sp_next_state
  import single_pulse_mem_pkg::*;
(
  input  logic [ST_W-1:0] cur_i,
  input  logic            lvl_i,
  output logic [ST_W-1:0] nxt_o
);
  logic a, b;
  assign a = cur_i[A_BIT];
  assign b = cur_i[B_BIT];

  always_comb begin
    nxt_o        = '0;
    nxt_o[A_BIT] = (~b & lvl_i) | (a & ~b);
    nxt_o[B_BIT] = a | (b & lvl_i);
  end
endmodule

// File: rtl/sp_state_reg.sv
module sp_state_reg #(
  parameter int unsigned        WIDTH   = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= RST_VAL[i];
      else         q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/sp_out_dec.sv
module sp_out_dec
  import single_pulse_mem_pkg::*;
(
  input  logic [ST_W-1:0] cur_i,
  output logic            pulse_o,
  output logic            held_o
);
  always_comb begin
    pulse_o = 1'b0;
    held_o  = 1'b0;
    unique case (sp_state_e'(cur_i))
      SP_FIRE: pulse_o = 1'b1;
      SP_MARK: held_o  = 1'b1;
      SP_WAIT: held_o  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/single_pulse_mem.sv
module single_pulse_mem
  import single_pulse_mem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o,
  output logic held_o
);
  logic [ST_W-1:0] state_q, state_d;

  sp_next_state u_next (
    .cur_i (state_q),
    .lvl_i (lvl_i),
    .nxt_o (state_d)
  );

  sp_state_reg #(
    .WIDTH   (ST_W),
    .RST_VAL (SP_IDLE)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  sp_out_dec u_dec (
    .cur_i   (state_q),
    .pulse_o (pulse_o),
    .held_o  (held_o)
  );
endmodule

// File: rtl/single_pulse_mem_chk.sv
module single_pulse_mem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lvl_i,
  input logic pulse_o,
  input logic held_o
);
  logic was_pulse_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) was_pulse_q <= 1'b0;
    else         was_pulse_q <= pulse_o;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_o && !held_o)); // R1
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !held_o && lvl_i) |=> pulse_o); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R2
  AST_FIRE_TO_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> held_o); // R3
  AST_MARK_TO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && was_pulse_q) |=> held_o); // R3
  AST_WAIT_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !was_pulse_q && lvl_i) |=> (held_o && !pulse_o)); // R4
  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !was_pulse_q && !lvl_i) |=> (!held_o && !pulse_o)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !held_o && !lvl_i) |=> (!pulse_o && !held_o)); // R5
  AST_NO_REPULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |=> !pulse_o); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_o && held_o)); // R7
endmodule

bind single_pulse_mem single_pulse_mem_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .lvl_i   (lvl_i),
  .pulse_o (pulse_o),
  .held_o  (held_o)
);

// File: tb/single_pulse_mem_tb_top.sv
`timescale 1ns/1ps
module single_pulse_mem_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lvl_i = 1'b0;
  logic pulse_o, held_o;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  single_pulse_mem dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl_i),
    .pulse_o (pulse_o),
    .held_o  (held_o)
  );

  // {lvl applied before edge, expected pulse_o, expected held_o after edge}
  localparam int NV = 21;
  localparam logic [2:0] VEC [NV] = '{
    3'b000,                                  // idle stays (R5)
    3'b110, 3'b101, 3'b101, 3'b101, 3'b000,  // long request (R2 R3 R4 R5)
    3'b110, 3'b001, 3'b001, 3'b000,          // drop in fire (R3 R6)
    3'b110, 3'b001, 3'b101, 3'b101, 3'b000,  // one-cycle, re-raise in mark (R6)
    3'b000,
    3'b110, 3'b101, 3'b001, 3'b101, 3'b000   // drop in mark, re-raise in wait (R4 R6)
  };

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {pulse,held} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    lvl_i = 1'b1;
    repeat (2) @(posedge clk_i);
    #1 check("R1 reset idle", {pulse_o, held_o}, 2'b00);
    @(negedge clk_i);
    lvl_i  = 1'b0;
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      lvl_i = VEC[i][2];
      @(posedge clk_i);
      #1;
      check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d", i), {pulse_o, held_o}, VEC[i][1:0]);
      if (pulse_o && held_o) check("R7 exclusive", 2'b11, 2'b00);
    end

    // R1: reset mid-sequence, right after a pulse
    @(negedge clk_i);
    lvl_i = 1'b1;
    @(posedge clk_i);
    #1 check("R2 pulse before reset", {pulse_o, held_o}, 2'b10);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5 check("R1 async reset mid-seq", {pulse_o, held_o}, 2'b00);
    @(posedge clk_i);
    #1 check("R1 held in reset", {pulse_o, held_o}, 2'b00);
    @(negedge clk_i);
    lvl_i  = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1 check("R1 idle after reset", {pulse_o, held_o}, 2'b00);
    @(negedge clk_i);
    lvl_i = 1'b1;
    @(posedge clk_i);
    #1 check("R2 fresh pulse after reset", {pulse_o, held_o}, 2'b10);
    @(posedge clk_i);
    #1 check("R3 mark after reset", {pulse_o, held_o}, 2'b01);
    repeat (3) @(posedge clk_i);
    #1 check("R6 no repulse on long hold", {pulse_o, held_o}, 2'b01);
    finish_run();
  end
endmodule